// File: doc/BRIEF.md
# Latching Interrupt Controller

This block sits beside a processor core and gathers thirty-two external interrupt request lines into one interrupt output. Each line passes through a two-flop synchronizer and is then captured into a status register. A mask register, one bit per line, decides which pending lines may reach the core. The core output is a registered OR of every status bit whose mask bit is set.

A build-time parameter selects one of three capture styles. In follow-the-level style, each status bit mirrors its synchronized line and needs no acknowledge. In edge style, a rising edge latches the bit, and software clears it by writing a 1 to it. In legacy latched style, a high level latches the bit, and software clears it by writing a 0 to it. In legacy style, software acknowledges one line by writing back the status value with only that bit cleared.

Software reaches both registers through a plain port. A select bit chooses the register, a write strobe carries 32-bit data, and the read data for the selected register is combinational. Software scans the status word from bit 0 upward to find pending lines.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After a synchronous reset, the mask register, the status register and `cpu_irq` are all zero.
- R2: With `reg_sel`=0 a write loads the whole mask register, and bit i enables line i. `reg_rdata` returns the mask when `reg_sel`=0 and the status when `reg_sel`=1, in the same cycle.
- R3: `cpu_irq` equals the OR of (status AND mask) as it stood one clock earlier, so it changes one cycle after the mask or status changes.
- R4: In follow-the-level style, status bit i equals line i after the two synchronizer flops plus the status flop (three clocks), and writes to the status register have no effect.
- R5: In edge style, a 0-to-1 transition of line i sets status bit i. The bit stays set after the line falls. A line that stays high does not set the bit again.
- R6: In edge style, writing status with bit i = 1 clears bit i. Writing 0 to a bit leaves it unchanged.
- R7: In edge style, when a rising edge on line i and a write-1 acknowledge of bit i take effect on the same clock, the bit remains set. Other bits acknowledged in that same write are cleared.
- R8: In legacy style, a high level on line i sets status bit i, and the bit stays set after the line falls.
- R9: In legacy style, writing status with bit i = 0 clears bit i. Writing 1 to a bit leaves it unchanged.
- R10: In legacy style, a line that is still high keeps its status bit set through a write-0 acknowledge.
- R11: A status bit whose mask bit is 0 never raises `cpu_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Asynchronous interrupt request lines, bit i is line i |
| reg_sel | input | 1 | Register select: 0 mask, 1 status |
| reg_we | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the selected register |
| cpu_irq | output | 1 | Registered interrupt request to the core |

## Verification
The risky overlap is a new capture of a line and a software acknowledge of that same line landing on one clock edge. In edge style, the bench first latches a line and lets it fall. It then raises the line again and times a write-1 acknowledge so that the write is active on exactly the edge where the new edge event registers. The bit must survive while a second acknowledged bit clears. In legacy style, the same overlap is provoked by holding a line high through a write-0 acknowledge, and the status bit must stay set.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

  typedef enum logic [1:0] {
    CAP_LEVEL   = 2'd0,
    CAP_EDGE    = 2'd1,
    CAP_LATCH_Z = 2'd2
  } cap_mode_e;

  localparam logic SEL_MASK   = 1'b0;
  localparam logic SEL_STATUS = 1'b1;

  // Bits that a write to the status register asks to clear.
  function automatic logic [31:0] ack_bits(input cap_mode_e mode, input logic [31:0] wd);
    case (mode)
      CAP_EDGE:    ack_bits = wd;
      CAP_LATCH_Z: ack_bits = ~wd;
      default:     ack_bits = '0;
    endcase
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture
  import irq_latch_pkg::*;
#(
  parameter int        W    = 32,
  parameter cap_mode_e MODE = CAP_EDGE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_sync,
  input  logic         st_we,
  input  logic [W-1:0] st_wdata,
  output logic [W-1:0] set_vec,
  output logic [W-1:0] status_q
);
  generate
    if (MODE == CAP_LEVEL) begin : g_level
      logic unused_wr;
      assign unused_wr = ^{st_we, st_wdata};
      assign set_vec   = line_sync;
      always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= line_sync;
      end
    end else begin : g_latch
      logic [W-1:0] clr_vec;
      if (MODE == CAP_EDGE) begin : g_edge
        logic [W-1:0] prev_q;
        always_ff @(posedge clk) begin
          if (rst) prev_q <= '0;
          else     prev_q <= line_sync;
        end
        assign set_vec = line_sync & ~prev_q;
        assign clr_vec = st_we ? st_wdata : '0;
      end else begin : g_zero
        assign set_vec = line_sync;
        assign clr_vec = st_we ? ~st_wdata : '0;
      end
      // A new capture outranks an acknowledge landing on the same edge.
      always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_vec) | set_vec;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_regport.sv
module irq_regport
  import irq_latch_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_sel,
  input  logic         reg_we,
  input  logic [W-1:0] reg_wdata,
  input  logic [W-1:0] status_q,
  output logic         st_we,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] reg_rdata,
  output logic         cpu_irq
);
  logic mask_we;

  assign mask_we = reg_we && (reg_sel == SEL_MASK);
  assign st_we   = reg_we && (reg_sel == SEL_STATUS);

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_we) mask_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= |(status_q & mask_q);
  end

  assign reg_rdata = (reg_sel == SEL_STATUS) ? status_q : mask_q;
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_latch_pkg::*;
#(
  parameter int        N_LINES     = 32,
  parameter int        SYNC_STAGES = 2,
  parameter cap_mode_e CAP_MODE    = CAP_EDGE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [N_LINES-1:0] reg_wdata,
  output logic [N_LINES-1:0] reg_rdata,
  output logic               cpu_irq
);
  logic [N_LINES-1:0] line_sync;
  logic [N_LINES-1:0] line_set;
  logic [N_LINES-1:0] status_q;
  logic [N_LINES-1:0] mask_q;
  logic               st_we;

  irq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(line_sync)
  );

  irq_capture #(.W(N_LINES), .MODE(CAP_MODE)) u_cap (
    .clk(clk), .rst(rst), .line_sync(line_sync), .st_we(st_we),
    .st_wdata(reg_wdata), .set_vec(line_set), .status_q(status_q)
  );

  irq_regport #(.W(N_LINES)) u_port (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .status_q(status_q), .st_we(st_we),
    .mask_q(mask_q), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );
endmodule

// File: rtl/irq_latch_ctrl_chk.sv
module irq_latch_ctrl_chk
  import irq_latch_pkg::*;
#(
  parameter int        W    = 32,
  parameter cap_mode_e MODE = CAP_EDGE
) (
  input logic         clk,
  input logic         rst,
  input logic         reg_we,
  input logic         reg_sel,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] synced,
  input logic [W-1:0] set_vec,
  input logic [W-1:0] status,
  input logic [W-1:0] mask,
  input logic         cpu_irq
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == '0 && mask == '0 && !cpu_irq));

  p_mask_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(reg_we && reg_sel == SEL_MASK)) |-> mask == $past(reg_wdata));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_we && reg_sel == SEL_MASK)) |-> $stable(mask));

  p_irq_follow_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cpu_irq == (|$past(status & mask)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status & $past(set_vec)) == $past(set_vec)));

  generate
    if (MODE == CAP_LEVEL) begin : g_lvl
      p_level_track_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> status == $past(synced));
    end else begin : g_lat
      p_no_silent_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_we && reg_sel == SEL_STATUS)) |-> (($past(status) & ~status) == '0));
    end
  endgenerate
endmodule

bind irq_latch_ctrl irq_latch_ctrl_chk #(.W(N_LINES), .MODE(CAP_MODE)) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .synced(line_sync), .set_vec(line_set), .status(status_q), .mask(mask_q),
  .cpu_irq(cpu_irq)
);

// File: tb/irq_latch_ctrl_test.sv
`timescale 1ns/1ps
module irq_latch_ctrl_test;
  import irq_latch_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        reg_sel = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_edge, rd_lvl, rd_leg;
  logic        irq_edge, irq_lvl, irq_leg;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_latch_ctrl #(.CAP_MODE(CAP_EDGE)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_edge), .cpu_irq(irq_edge));
  irq_latch_ctrl #(.CAP_MODE(CAP_LEVEL)) uut_lvl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_lvl), .cpu_irq(irq_lvl));
  irq_latch_ctrl #(.CAP_MODE(CAP_LATCH_Z)) uut_leg (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_leg), .cpu_irq(irq_leg));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; irq_in = '0; reg_we = 1'b0; reg_sel = SEL_MASK; reg_wdata = '0;
    idle(3);
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic view(input logic sel);
    reg_sel = sel;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    view(SEL_MASK);
    chk("R1 mask edge", rd_edge, '0);
    chk("R1 mask legacy", rd_leg, '0);
    view(SEL_STATUS);
    chk("R1 status edge", rd_edge, '0);
    chk("R1 status level", rd_lvl, '0);
    chk("R1 status legacy", rd_leg, '0);
    chk("R1 cpu_irq", {29'd0, irq_edge, irq_lvl, irq_leg}, '0);
  endtask

  task automatic t_mask();
    do_reset();
    wr(SEL_MASK, 32'hA5A5_0F01);
    view(SEL_MASK);
    chk("R2 mask readback", rd_edge, 32'hA5A5_0F01);
    wr(SEL_MASK, 32'h8000_0000);
    view(SEL_MASK);
    chk("R2 mask rewrite", rd_edge, 32'h8000_0000);
    view(SEL_STATUS);
    chk("R2 status select", rd_edge, '0);
  endtask

  task automatic t_level();
    do_reset();
    @(negedge clk); irq_in = 32'h8000_0011;
    idle(2);
    view(SEL_STATUS);
    chk("R4 level not yet", rd_lvl, '0);
    idle(1);
    view(SEL_STATUS);
    chk("R4 level after three clocks", rd_lvl, 32'h8000_0011);
    wr(SEL_STATUS, 32'hFFFF_FFFF);
    view(SEL_STATUS);
    chk("R4 write ones ignored", rd_lvl, 32'h8000_0011);
    wr(SEL_STATUS, 32'h0000_0000);
    view(SEL_STATUS);
    chk("R4 write zeros ignored", rd_lvl, 32'h8000_0011);
    irq_in = '0;
    idle(4);
    view(SEL_STATUS);
    chk("R4 level falls", rd_lvl, '0);
  endtask

  task automatic t_edge();
    do_reset();
    @(negedge clk); irq_in = 32'h0000_0104;
    idle(4);
    irq_in = 32'h0000_0200;
    idle(4);
    view(SEL_STATUS);
    chk("R5 edge latched", rd_edge, 32'h0000_0304);
    wr(SEL_STATUS, 32'h0000_0000);
    view(SEL_STATUS);
    chk("R6 write zero no effect", rd_edge, 32'h0000_0304);
    wr(SEL_STATUS, 32'h0000_0204);
    idle(3);
    view(SEL_STATUS);
    chk("R5 R6 held-high line not re-set after ack", rd_edge, 32'h0000_0100);
  endtask

  task automatic t_collide();
    do_reset();
    @(negedge clk); irq_in = 32'h0000_0044;
    idle(4);
    irq_in = '0;
    idle(4);
    view(SEL_STATUS);
    chk("R7 pre-latched", rd_edge, 32'h0000_0044);
    irq_in = 32'h0000_0040;
    idle(2);
    reg_we = 1'b1; reg_sel = SEL_STATUS; reg_wdata = 32'h0000_0044;
    @(negedge clk);
    reg_we = 1'b0;
    view(SEL_STATUS);
    chk("R7 edge beats ack", rd_edge, 32'h0000_0040);
  endtask

  task automatic t_legacy();
    do_reset();
    @(negedge clk); irq_in = 32'h0000_0030;
    idle(4);
    irq_in = '0;
    idle(4);
    view(SEL_STATUS);
    chk("R8 level latched", rd_leg, 32'h0000_0030);
    wr(SEL_STATUS, 32'hFFFF_FFFF);
    view(SEL_STATUS);
    chk("R9 write ones no effect", rd_leg, 32'h0000_0030);
    wr(SEL_STATUS, 32'hFFFF_FFEF);
    view(SEL_STATUS);
    chk("R9 write zero clears", rd_leg, 32'h0000_0020);
    irq_in = 32'h0000_0001;
    idle(4);
    wr(SEL_STATUS, 32'h0000_0000);
    view(SEL_STATUS);
    chk("R10 held line survives ack", rd_leg, 32'h0000_0001);
    irq_in = '0;
    idle(4);
    wr(SEL_STATUS, 32'h0000_0000);
    view(SEL_STATUS);
    chk("R10 cleared after drop", rd_leg, 32'h0000_0000);
  endtask

  task automatic t_irq();
    do_reset();
    @(negedge clk); irq_in = 32'h0000_0008;
    idle(6);
    chk("R11 masked line silent", {31'd0, irq_edge}, 32'd0);
    wr(SEL_MASK, 32'hFFFF_FFF7);
    idle(2);
    chk("R11 other mask bits silent", {31'd0, irq_edge}, 32'd0);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = SEL_MASK; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R3 not yet after mask", {31'd0, irq_edge}, 32'd0);
    @(negedge clk);
    chk("R3 one clock later", {31'd0, irq_edge}, 32'd1);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = SEL_STATUS; reg_wdata = 32'h0000_0008;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R3 still high after ack edge", {31'd0, irq_edge}, 32'd1);
    @(negedge clk);
    chk("R3 falls one clock after ack", {31'd0, irq_edge}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_mask();
    t_level();
    t_edge();
    t_collide();
    t_legacy();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule